// File: doc/BRIEF.md
# Lockable video register write port

This block is the host-facing control port of a video display processor that carries an extended register file next to the legacy eight registers. The host writes bytes to the control port in pairs: a data byte, then a command byte. A command byte with top bits `10` names a register and commits the data byte into it. A command byte with top bits `00` or `01` is a memory-address setup and is handed on to the memory side.

A lock decides how much of the register number is decoded. While locked, the port behaves like the legacy part: only the low three register-number bits matter. Two back-to-back writes of a fixed value to a fixed register open the lock. A reset command then restores every register default and closes the lock again. Palette storage sits beside the register file and is not touched by that command.

A status-select register chooses which of two status bytes a host status read returns. Software can therefore tell the extended part from the legacy one.

Top module: `vreg_port`

## Requirements
- R1: After `rst_ni` deasserts, `locked_o` is 1. Every register holds its default: register 51 holds 0x20 and all other registers hold 0x00. `status_o` equals `stat_legacy_i`, and every palette entry is 0.
- R2: While locked, a register write uses only bits [2:0] of the register number. For example, command 0x8A writes register 2. Registers 8 and up do not change.
- R3: While unlocked, all six register-number bits are decoded. A register number of `NREG` (58) or more is discarded, and the register contents stay unchanged.
- R4: Two consecutive register writes of data 0x1C to register number 57 (command 0xB9) clear `locked_o`. The match uses all six bits even while locked. While locked, each such write also stores 0x1C into register 1. Any other register write in between restarts the sequence. Address setups do not restart it.
- R5: While unlocked, a register write to number 50 with data bit 7 set restores every register default and sets `locked_o`. While locked, the same command writes register 2 instead.
- R6: The reset command of R5 leaves all palette entries unchanged.
- R7: `status_o` returns `stat_legacy_i` when register 15 is 0x00, and returns `stat_ext_i` otherwise.
- R8: A second byte with bits [7:6] equal to 00 or 01 produces a one-cycle `vaddr_valid_o` pulse. `vaddr_o` is {second[5:0], first}, `vaddr_write_o` is second[6], and no register changes. A second byte with bits [7:6] equal to 11 is discarded.
- R9: A `host_rd_i` pulse returns the byte latch to expecting a first byte. A write in the same cycle as a read is ignored.
- R10: A register write becomes visible on the register outputs right after the clock edge at which the second byte is sampled. `vaddr_valid_o` is high in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_data_i | input | 8 | Control-port write data |
| host_wr_i | input | 1 | Control-port write strobe, one byte per cycle high |
| host_rd_i | input | 1 | Status read strobe |
| stat_legacy_i | input | 8 | Legacy status byte |
| stat_ext_i | input | 8 | Extended status byte |
| pal_wr_i | input | 1 | Palette entry write enable |
| pal_idx_i | input | 4 | Palette entry index |
| pal_data_i | input | 12 | Palette entry data |
| reg_flat_o | output | NREG*8 | Register contents, register n at bits [8n+7:8n] |
| locked_o | output | 1 | Lock engaged |
| status_o | output | 8 | Selected status byte |
| vaddr_valid_o | output | 1 | Address setup pulse |
| vaddr_o | output | 14 | Address from the setup pair |
| vaddr_write_o | output | 1 | Address setup is for a write |
| pal_flat_o | output | PAL_N*PAL_W | Palette contents, entry k at bits [12k+11:12k] |

## Verification
The unlock sequence is attacked in three ways: interrupted by an unrelated register write, interleaved with an address setup, and completed. A design that counted non-consecutive matches would unlock early. A design that let address setups reset the counter would never unlock in the interleaved case.

Writes to high register numbers are issued while locked. A design that decoded all six bits would corrupt extended registers instead of aliasing onto registers 0 to 7.

The reset command is sent after palette writes and after extended registers have been changed. A design that wiped the palette, or skipped relocking, would show up at the ports. The bench also sends the same command while locked, where it must land in register 2.

A status read between bytes must resynchronise the latch. A write in the same cycle as that read must not count, or every later pair would be misframed.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
  localparam int unsigned RNUM_W      = 6;
  localparam int unsigned LEGACY_W    = 3;
  localparam logic [5:0]  UNLOCK_REG  = 6'd57;
  localparam logic [7:0]  UNLOCK_VAL  = 8'h1C;
  localparam logic [5:0]  RESET_REG   = 6'd50;
  localparam int unsigned STAT_SEL    = 15;
  localparam int unsigned SPR_CNT_REG = 51;

  typedef enum logic [1:0] {
    K_ADDR_RD = 2'b00,
    K_ADDR_WR = 2'b01,
    K_REG_WR  = 2'b10,
    K_NONE    = 2'b11
  } cmd_kind_e;

  // legacy-compatible power-on values
  function automatic logic [7:0] reg_default(int unsigned n);
    return (n == SPR_CNT_REG) ? 8'h20 : 8'h00;
  endfunction
endpackage

// File: rtl/vreg_cmd_dec.sv
module vreg_cmd_dec
  import vreg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  data_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic        reg_wr_o,
  output logic [5:0]  reg_num_o,
  output logic [7:0]  reg_data_o,
  output logic        vaddr_valid_o,
  output logic [13:0] vaddr_o,
  output logic        vaddr_write_o
);
  logic [7:0] first_q;
  logic       second_q;
  logic       take;
  cmd_kind_e  kind;

  assign take       = wr_i && !rd_i;
  assign kind       = cmd_kind_e'(data_i[7:6]);
  assign reg_wr_o   = take && second_q && (kind == K_REG_WR);
  assign reg_num_o  = data_i[5:0];
  assign reg_data_o = first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q       <= '0;
      second_q      <= 1'b0;
      vaddr_valid_o <= 1'b0;
      vaddr_o       <= '0;
      vaddr_write_o <= 1'b0;
    end else begin
      vaddr_valid_o <= 1'b0;
      if (rd_i) begin
        second_q <= 1'b0;
      end else if (wr_i) begin
        if (!second_q) begin
          first_q  <= data_i;
          second_q <= 1'b1;
        end else begin
          second_q <= 1'b0;
          if (kind == K_ADDR_RD || kind == K_ADDR_WR) begin
            vaddr_valid_o <= 1'b1;
            vaddr_o       <= {data_i[5:0], first_q};
            vaddr_write_o <= data_i[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/vreg_lock.sv
module vreg_lock
  import vreg_pkg::*;
#(
  parameter int unsigned SEQ_LEN = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_wr_i,
  input  logic [5:0] reg_num_i,
  input  logic [7:0] reg_data_i,
  output logic       locked_o,
  output logic       reset_cmd_o
);
  localparam int unsigned CNT_W = $clog2(SEQ_LEN + 1);
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit         = reg_wr_i && reg_num_i == UNLOCK_REG && reg_data_i == UNLOCK_VAL;
  assign reset_cmd_o = reg_wr_i && !locked_o && reg_num_i == RESET_REG && reg_data_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b1;
      cnt_q    <= '0;
    end else if (reset_cmd_o) begin
      locked_o <= 1'b1;
      cnt_q    <= '0;
    end else if (reg_wr_i) begin
      if (!hit) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(SEQ_LEN - 1)) begin
        locked_o <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vreg_file.sv
module vreg_file
  import vreg_pkg::*;
#(
  parameter int unsigned NREG = 58
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [5:0]      addr_i,
  input  logic [7:0]      data_i,
  input  logic            load_dflt_i,
  output logic [NREG*8-1:0] regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           regs_o[i*8 +: 8] <= reg_default(i);
      else if (load_dflt_i)                  regs_o[i*8 +: 8] <= reg_default(i);
      else if (we_i && addr_i == 6'(i))      regs_o[i*8 +: 8] <= data_i;
    end
  end
endmodule

// File: rtl/vreg_palette.sv
module vreg_palette #(
  parameter int unsigned PAL_N = 16,
  parameter int unsigned PAL_W = 12,
  localparam int unsigned IDX_W = $clog2(PAL_N)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [PAL_W-1:0]       data_i,
  output logic [PAL_N*PAL_W-1:0] pal_o
);
  for (genvar k = 0; k < PAL_N; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        pal_o[k*PAL_W +: PAL_W] <= '0;
      else if (we_i && idx_i == IDX_W'(k)) pal_o[k*PAL_W +: PAL_W] <= data_i;
    end
  end
endmodule

// File: rtl/vreg_port.sv
module vreg_port
  import vreg_pkg::*;
#(
  parameter int unsigned NREG  = 58,
  parameter int unsigned PAL_N = 16,
  parameter int unsigned PAL_W = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [7:0]             host_data_i,
  input  logic                   host_wr_i,
  input  logic                   host_rd_i,
  input  logic [7:0]             stat_legacy_i,
  input  logic [7:0]             stat_ext_i,
  input  logic                   pal_wr_i,
  input  logic [3:0]             pal_idx_i,
  input  logic [11:0]            pal_data_i,
  output logic [NREG*8-1:0]      reg_flat_o,
  output logic                   locked_o,
  output logic [7:0]             status_o,
  output logic                   vaddr_valid_o,
  output logic [13:0]            vaddr_o,
  output logic                   vaddr_write_o,
  output logic [PAL_N*PAL_W-1:0] pal_flat_o
);
  logic       reg_wr, reset_cmd, file_we;
  logic [5:0] reg_num, eff_num;
  logic [7:0] reg_data;

  vreg_cmd_dec u_dec (
    .clk_i, .rst_ni,
    .data_i(host_data_i), .wr_i(host_wr_i), .rd_i(host_rd_i),
    .reg_wr_o(reg_wr), .reg_num_o(reg_num), .reg_data_o(reg_data),
    .vaddr_valid_o, .vaddr_o, .vaddr_write_o
  );

  vreg_lock #(.SEQ_LEN(2)) u_lock (
    .clk_i, .rst_ni,
    .reg_wr_i(reg_wr), .reg_num_i(reg_num), .reg_data_i(reg_data),
    .locked_o, .reset_cmd_o(reset_cmd)
  );

  // legacy aliasing: upper number bits dropped while locked
  assign eff_num = locked_o ? {{(RNUM_W-LEGACY_W){1'b0}}, reg_num[LEGACY_W-1:0]} : reg_num;
  assign file_we = reg_wr && (32'(eff_num) < NREG);

  vreg_file #(.NREG(NREG)) u_file (
    .clk_i, .rst_ni,
    .we_i(file_we), .addr_i(eff_num), .data_i(reg_data),
    .load_dflt_i(reset_cmd), .regs_o(reg_flat_o)
  );

  vreg_palette #(.PAL_N(PAL_N), .PAL_W(PAL_W)) u_pal (
    .clk_i, .rst_ni,
    .we_i(pal_wr_i), .idx_i(pal_idx_i), .data_i(pal_data_i), .pal_o(pal_flat_o)
  );

  assign status_o = (reg_flat_o[STAT_SEL*8 +: 8] == 8'h00) ? stat_legacy_i : stat_ext_i;
endmodule

module vreg_port_chk #(
  parameter int unsigned NREG  = 58,
  parameter int unsigned PAL_N = 16,
  parameter int unsigned PAL_W = 12
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   locked_o,
  input logic                   reg_wr,
  input logic [5:0]             reg_num,
  input logic [7:0]             reg_data,
  input logic                   reset_cmd,
  input logic                   pal_wr_i,
  input logic                   host_wr_i,
  input logic                   vaddr_valid_o,
  input logic [NREG*8-1:0]      reg_flat_o,
  input logic [PAL_N*PAL_W-1:0] pal_flat_o
);
  AST_LOCKED_HIGH_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> $stable(reg_flat_o[NREG*8-1:64])); // R2
  AST_UNLOCK_NEEDS_MAGIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(reg_wr && reg_num == 6'd57 && reg_data == 8'h1C)); // R4
  AST_RESET_RELOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_cmd |=> locked_o); // R5
  AST_PALETTE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_cmd && !pal_wr_i) |=> $stable(pal_flat_o)); // R6
  AST_VADDR_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vaddr_valid_o |-> $past(host_wr_i)); // R8
  AST_VADDR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vaddr_valid_o |=> !vaddr_valid_o || $past(host_wr_i)); // R10
endmodule

bind vreg_port vreg_port_chk #(.NREG(NREG), .PAL_N(PAL_N), .PAL_W(PAL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .locked_o(locked_o), .reg_wr(reg_wr),
  .reg_num(reg_num), .reg_data(reg_data), .reset_cmd(reset_cmd),
  .pal_wr_i(pal_wr_i), .host_wr_i(host_wr_i), .vaddr_valid_o(vaddr_valid_o),
  .reg_flat_o(reg_flat_o), .pal_flat_o(pal_flat_o)
);

// File: tb/vreg_port_test.sv
`timescale 1ns/1ps
module vreg_port_test;
  localparam int unsigned NREG = 58;
  logic clk = 0, rst_ni = 0;
  logic [7:0] host_data = 0, stat_legacy = 8'hA5, stat_ext = 8'h5A;
  logic host_wr = 0, host_rd = 0, pal_wr = 0;
  logic [3:0] pal_idx = 0;
  logic [11:0] pal_data = 0;
  logic [NREG*8-1:0] reg_flat;
  logic locked, vaddr_valid, vaddr_write;
  logic [7:0] status;
  logic [13:0] vaddr;
  logic [191:0] pal_flat;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  vreg_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .host_data_i(host_data), .host_wr_i(host_wr),
    .host_rd_i(host_rd), .stat_legacy_i(stat_legacy), .stat_ext_i(stat_ext),
    .pal_wr_i(pal_wr), .pal_idx_i(pal_idx), .pal_data_i(pal_data),
    .reg_flat_o(reg_flat), .locked_o(locked), .status_o(status),
    .vaddr_valid_o(vaddr_valid), .vaddr_o(vaddr), .vaddr_write_o(vaddr_write),
    .pal_flat_o(pal_flat)
  );

  function automatic logic [7:0] rg(int n);
    return reg_flat[n*8 +: 8];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wb(logic [7:0] b);
    @(negedge clk); host_data = b; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic wreg(logic [7:0] d, logic [7:0] c);
    wb(d); wb(c);
  endtask

  task automatic t_reset;
    chk("R1 locked", locked, 1);
    chk("R1 reg51", rg(51), 8'h20);
    chk("R1 reg0", rg(0), 0);
    chk("R1 reg15", rg(15), 0);
    chk("R1 status", status, 8'hA5);
    chk("R1 palette", pal_flat == '0, 1);
  endtask

  task automatic t_locked_decode;
    wreg(8'h33, 8'h8A);
    chk("R2 reg2 alias", rg(2), 8'h33);
    chk("R10 visible after edge", rg(2), 8'h33);
    chk("R2 reg10 untouched", rg(10), 0);
    wreg(8'h01, 8'h8F);
    chk("R2 reg7 alias of 15", rg(7), 8'h01);
    chk("R7 status still legacy", status, 8'hA5);
  endtask

  task automatic t_unlock;
    wreg(8'h1C, 8'hB9);
    chk("R4 reg1 side write", rg(1), 8'h1C);
    chk("R4 one write not enough", locked, 1);
    wreg(8'h00, 8'h81);
    wreg(8'h1C, 8'hB9);
    chk("R4 interrupted sequence", locked, 1);
    wb(8'h34); wb(8'h52);
    chk("R8 vaddr valid", vaddr_valid, 1);
    chk("R8 vaddr", vaddr, 14'h1234);
    chk("R8 vaddr write", vaddr_write, 1);
    @(negedge clk);
    chk("R10 vaddr pulse one cycle", vaddr_valid, 0);
    wreg(8'h1C, 8'hB9);
    chk("R4 unlocked", locked, 0);
    wreg(8'h00, 8'h81);
  endtask

  task automatic t_unlocked_decode;
    logic [NREG*8-1:0] snap;
    wreg(8'h44, 8'h8A);
    chk("R3 reg10 written", rg(10), 8'h44);
    chk("R3 reg2 kept", rg(2), 8'h33);
    snap = reg_flat;
    wreg(8'h77, 8'hBC);
    chk("R3 reg60 discarded", reg_flat == snap, 1);
    wreg(8'h01, 8'h8F);
    chk("R7 ext status", status, 8'h5A);
    wreg(8'h00, 8'h8F);
    chk("R7 legacy status", status, 8'hA5);
  endtask

  task automatic t_vaddr;
    logic [NREG*8-1:0] snap;
    wb(8'h11); wb(8'h0F);
    chk("R8 read setup addr", vaddr, 14'h0F11);
    chk("R8 read setup flag", vaddr_write, 0);
    snap = reg_flat;
    wb(8'h99); wb(8'hC3);
    chk("R8 prefix 11 no setup", vaddr_valid, 0);
    chk("R8 prefix 11 no reg", reg_flat == snap, 1);
  endtask

  task automatic t_latch;
    wb(8'h55);
    @(negedge clk); host_rd = 1;
    @(negedge clk); host_rd = 0;
    wreg(8'h66, 8'h83);
    chk("R9 read resync", rg(3), 8'h66);
    wb(8'h21);
    @(negedge clk); host_rd = 1; host_wr = 1; host_data = 8'h84;
    @(negedge clk); host_rd = 0; host_wr = 0;
    chk("R9 write with read ignored", rg(4), 0);
    wreg(8'h42, 8'h84);
    chk("R9 next pair framed", rg(4), 8'h42);
  endtask

  task automatic t_reset_cmd;
    @(negedge clk); pal_wr = 1; pal_idx = 3; pal_data = 12'hABC;
    @(negedge clk); pal_wr = 0;
    wreg(8'h05, 8'hB3);
    chk("R3 reg51 set", rg(51), 8'h05);
    wreg(8'h80, 8'hB2);
    chk("R5 relocked", locked, 1);
    chk("R5 reg51 default", rg(51), 8'h20);
    chk("R5 reg10 default", rg(10), 0);
    chk("R5 reg50 default", rg(50), 0);
    chk("R6 palette kept", pal_flat[3*12 +: 12], 12'hABC);
    wreg(8'h80, 8'hB2);
    chk("R5 locked cmd to reg2", rg(2), 8'h80);
    chk("R5 locked stays", locked, 1);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset;
    t_locked_decode;
    t_unlock;
    t_unlocked_decode;
    t_vaddr;
    t_latch;
    t_reset_cmd;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule